// File: doc/BRIEF.md
# Synchronous Dual-Port RAM with Per-Port Output Mode

This block is a two-port static RAM in which a left and a right port reach one shared storage array at the same time, and either port may read or write any word, including the word the other port is using. Each port has its own address, write data, read data, read/write select, a pair of chip enables of opposite polarity, an asynchronous active-low output enable and an output-mode select. Depth and word width (8 or 9 bits) are parameters. Both ports run on one common clock, and the block has a synchronous active-low reset.

A read is captured at a clock edge. In flow-through mode (mode select low) the word is presented in the cycle that follows that edge. In registered mode (mode select high) the word passes through one more output register and is presented one cycle later. The mode pin is a level: it selects which of the two output stages is presented, so it can be changed from one cycle to the next. A read-data valid flag stands in for the tri-state output. Whenever the flag is low, the read data is forced to zero.

Top module: `dual_port_ram`

## Requirements
- R1: A port is selected only when its active-low chip enable is 0 and its active-high chip enable is 1 at a clock edge. A write presented while the port is deselected leaves memory unchanged, and a read presented while it is deselected produces no valid output.
- R2: Write select 0 at a selected edge stores the write data at the address. Write select 1 at a selected edge is a read.
- R3: With mode select 0, a read captured at edge k gives valid data equal to the memory word after edge k, until edge k+1.
- R4: With mode select 1, the word read at edge k is presented, valid, after edge k+1.
- R5: Output enable 1 forces the valid flag to 0 at once, with no clock edge. It does not change writes, reads or the pipeline state.
- R6: The output state is set by earlier control. In flow-through mode the valid flag follows the edge just past, and in registered mode it follows the edge before that. A write or a deselect at that edge gives valid 0, so after a deselect one selected read is needed before the output comes back.
- R7: When one port writes a word and the other port reads the same word at the same edge, the read returns the old contents. The new value is read from the next edge on.
- R8: When both ports write the same word at the same edge, the left port's data is stored.
- R9: While reset is low at an edge, and after it, both valid flags are 0 and both read data buses are 0 until a read is captured.
- R10: The mode select may change between cycles. The port then presents the chosen stage (flow-through or registered) in that same cycle.
- R11: Whenever a port's valid flag is 0, its read data is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock for both ports |
| rst_n | input | 1 | Synchronous active-low reset |
| l_ce_n | input | 1 | Left chip enable, active low |
| l_ce | input | 1 | Left chip enable, active high |
| l_wr_n | input | 1 | Left write select, 0 write, 1 read |
| l_oe_n | input | 1 | Left output enable, active low, asynchronous |
| l_pipe | input | 1 | Left output mode, 0 flow-through, 1 registered |
| l_addr | input | AW | Left word address |
| l_wdata | input | WIDTH | Left write data |
| l_rdata | output | WIDTH | Left read data, 0 when not valid |
| l_rvalid | output | 1 | Left read data valid |
| r_ce_n | input | 1 | Right chip enable, active low |
| r_ce | input | 1 | Right chip enable, active high |
| r_wr_n | input | 1 | Right write select, 0 write, 1 read |
| r_oe_n | input | 1 | Right output enable, active low, asynchronous |
| r_pipe | input | 1 | Right output mode, 0 flow-through, 1 registered |
| r_addr | input | AW | Right word address |
| r_wdata | input | WIDTH | Right write data |
| r_rdata | output | WIDTH | Right read data, 0 when not valid |
| r_rvalid | output | 1 | Right read data valid |

## Verification
A stored word corrupted by a collision or by a deselected write stays hidden until some port reads that address. It then shows as a wrong read word one cycle after the capture edge in flow-through mode, or two cycles after it in registered mode. A stuck stage flag shows sooner: the valid flag goes wrong in the first cycle after a write, a deselect or a mode change. The reference model is therefore compared on every clock, with both output stages in use, while addresses are kept in a small range so that reads often return to words that have just been written.

// File: rtl/dpr_pkg.sv
// Package for the dual-port RAM: the output-mode encoding and the rule
// that turns the two chip enables into one select. Assumes nothing else.
package dpr_pkg;

    // Output path that a port presents
    typedef enum logic {
        OUT_FLOW = 1'b0,
        OUT_REG  = 1'b1
    } out_mode_e;

    // A port is selected only with the low enable low and the high enable high
    function automatic logic port_selected(input logic ce_lo_n, input logic ce_hi);
        return (!ce_lo_n) && ce_hi;
    endfunction

endpackage

// File: rtl/dpr_array.sv
// Storage array with two synchronous ports on one clock.
// Each port has a registered read: the word is captured at the edge, before
// any write at that edge, so a read that collides with a write returns the
// old contents. When both ports write the same word, the left port wins.
// Assumes: the write/read strobes come from the port control, already
// qualified by chip enable. The storage itself is not reset.
module dpr_array #(
    parameter int DEPTH = 256,
    parameter int WIDTH = 9,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             a_we,
    input  logic             a_re,
    input  logic [AW-1:0]    a_addr,
    input  logic [WIDTH-1:0] a_wdata,
    output logic [WIDTH-1:0] a_rdata,
    input  logic             b_we,
    input  logic             b_re,
    input  logic [AW-1:0]    b_addr,
    input  logic [WIDTH-1:0] b_wdata,
    output logic [WIDTH-1:0] b_rdata
);

    logic [WIDTH-1:0] mem [DEPTH];

    // Read capture on both ports first, then writes; the later write (port a) has priority
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_rdata <= '0;
            b_rdata <= '0;
        end else begin
            if (a_re) a_rdata <= mem[a_addr];
            if (b_re) b_rdata <= mem[b_addr];
            if (b_we) mem[b_addr] <= b_wdata;
            if (a_we) mem[a_addr] <= a_wdata;
        end
    end

endmodule

// File: rtl/dpr_port.sv
// Control and output path for one port.
// It qualifies the chip enables and splits the access into write and read
// strobes for the array. It keeps a stage-1 valid flag beside the array's
// read register and a stage-2 copy of both. The mode pin chooses which stage
// is presented; the output enable then gates the valid flag asynchronously.
// Assumes: arr_rdata is the array's registered read word for this port.
module dpr_port #(
    parameter int WIDTH = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ce_lo_n,
    input  logic             ce_hi,
    input  logic             wr_n,
    input  logic             oe_n,
    input  logic             pipe,
    input  logic [WIDTH-1:0] arr_rdata,
    output logic             wr_en,
    output logic             rd_en,
    output logic [WIDTH-1:0] rdata,
    output logic             rvalid
);
    import dpr_pkg::*;

    logic             sel;
    logic             st1_vld;
    logic             st2_vld;
    logic [WIDTH-1:0] st2_data;
    logic             pick_vld;
    logic [WIDTH-1:0] pick_data;
    out_mode_e        mode;

    // Decode the access type from the enables and write select
    always_comb begin
        sel   = port_selected(ce_lo_n, ce_hi);
        wr_en = sel && !wr_n;
        rd_en = sel && wr_n;
        mode  = out_mode_e'(pipe);
    end

    // Stage-1 flag: a read was captured at the last edge
    always_ff @(posedge clk) begin
        if (!rst_n) st1_vld <= 1'b0;
        else        st1_vld <= rd_en;
    end

    // Stage-2 register: delays stage 1 by one more cycle for registered mode
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st2_vld  <= 1'b0;
            st2_data <= '0;
        end else begin
            st2_vld  <= st1_vld;
            st2_data <= arr_rdata;
        end
    end

    // Present the stage chosen by the mode pin, gated by the output enable
    always_comb begin
        pick_vld  = (mode == OUT_REG) ? st2_vld  : st1_vld;
        pick_data = (mode == OUT_REG) ? st2_data : arr_rdata;
        rvalid    = pick_vld && !oe_n;
        rdata     = rvalid ? pick_data : '0;
    end

endmodule

// File: rtl/dual_port_ram.sv
// Top of the dual-port RAM: two port controllers around one shared array.
// The left port is wired to the array's priority port, so it wins a
// same-word write collision. Assumes one common clock for both ports.
module dual_port_ram #(
    parameter int DEPTH = 256,
    parameter int WIDTH = 9,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             l_ce_n,
    input  logic             l_ce,
    input  logic             l_wr_n,
    input  logic             l_oe_n,
    input  logic             l_pipe,
    input  logic [AW-1:0]    l_addr,
    input  logic [WIDTH-1:0] l_wdata,
    output logic [WIDTH-1:0] l_rdata,
    output logic             l_rvalid,
    input  logic             r_ce_n,
    input  logic             r_ce,
    input  logic             r_wr_n,
    input  logic             r_oe_n,
    input  logic             r_pipe,
    input  logic [AW-1:0]    r_addr,
    input  logic [WIDTH-1:0] r_wdata,
    output logic [WIDTH-1:0] r_rdata,
    output logic             r_rvalid
);

    logic             l_we, l_re, r_we, r_re;
    logic [WIDTH-1:0] l_arr_q, r_arr_q;

    dpr_port #(.WIDTH(WIDTH)) u_left (
        .clk(clk), .rst_n(rst_n), .ce_lo_n(l_ce_n), .ce_hi(l_ce), .wr_n(l_wr_n),
        .oe_n(l_oe_n), .pipe(l_pipe), .arr_rdata(l_arr_q),
        .wr_en(l_we), .rd_en(l_re), .rdata(l_rdata), .rvalid(l_rvalid)
    );

    dpr_port #(.WIDTH(WIDTH)) u_right (
        .clk(clk), .rst_n(rst_n), .ce_lo_n(r_ce_n), .ce_hi(r_ce), .wr_n(r_wr_n),
        .oe_n(r_oe_n), .pipe(r_pipe), .arr_rdata(r_arr_q),
        .wr_en(r_we), .rd_en(r_re), .rdata(r_rdata), .rvalid(r_rvalid)
    );

    dpr_array #(.DEPTH(DEPTH), .WIDTH(WIDTH), .AW(AW)) u_array (
        .clk(clk), .rst_n(rst_n),
        .a_we(l_we), .a_re(l_re), .a_addr(l_addr), .a_wdata(l_wdata), .a_rdata(l_arr_q),
        .b_we(r_we), .b_re(r_re), .b_addr(r_addr), .b_wdata(r_wdata), .b_rdata(r_arr_q)
    );

endmodule

// File: rtl/dual_port_ram_chk.sv
// Assertion checker for dual_port_ram, bound to every instance.
// It watches the port pins only and assumes the common clock and the
// synchronous active-low reset of the top.
module dual_port_ram_chk #(
    parameter int WIDTH = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             l_ce_n,
    input logic             l_ce,
    input logic             l_wr_n,
    input logic             l_oe_n,
    input logic             l_pipe,
    input logic [WIDTH-1:0] l_rdata,
    input logic             l_rvalid,
    input logic             r_ce_n,
    input logic             r_ce,
    input logic             r_wr_n,
    input logic             r_oe_n,
    input logic             r_pipe,
    input logic [WIDTH-1:0] r_rdata,
    input logic             r_rvalid
);

    // R5
    l_oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n) l_oe_n |-> !l_rvalid);
    // R5
    r_oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n) r_oe_n |-> !r_rvalid);

    // R11
    l_zero_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) !l_rvalid |-> (l_rdata == '0));
    // R11
    r_zero_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) !r_rvalid |-> (r_rdata == '0));

    // R3
    l_flow_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!l_ce_n && l_ce && l_wr_n) |=> (l_pipe || l_oe_n || l_rvalid));
    // R3
    r_flow_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!r_ce_n && r_ce && r_wr_n) |=> (r_pipe || r_oe_n || r_rvalid));

    // R6
    l_flow_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (l_ce_n || !l_ce || !l_wr_n) |=> (l_pipe || !l_rvalid));
    // R6
    r_flow_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_ce_n || !r_ce || !r_wr_n) |=> (r_pipe || !r_rvalid));

    // R4
    l_reg_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (l_pipe && !l_oe_n && $past(rst_n) && $past(rst_n, 2)
         && $past(!l_ce_n && l_ce && l_wr_n, 2)) |-> l_rvalid);
    // R4
    r_reg_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_pipe && !r_oe_n && $past(rst_n) && $past(rst_n, 2)
         && $past(!r_ce_n && r_ce && r_wr_n, 2)) |-> r_rvalid);

endmodule

bind dual_port_ram dual_port_ram_chk #(.WIDTH(WIDTH)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .l_ce_n(l_ce_n), .l_ce(l_ce), .l_wr_n(l_wr_n), .l_oe_n(l_oe_n), .l_pipe(l_pipe),
    .l_rdata(l_rdata), .l_rvalid(l_rvalid),
    .r_ce_n(r_ce_n), .r_ce(r_ce), .r_wr_n(r_wr_n), .r_oe_n(r_oe_n), .r_pipe(r_pipe),
    .r_rdata(r_rdata), .r_rvalid(r_rvalid)
);

// File: tb/dual_port_ram_tb.sv
module dual_port_ram_tb;
    localparam int DEPTH = 256;
    localparam int WIDTH = 9;
    localparam int AW    = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    // index 0 = left, 1 = right
    logic             ce_n [2];
    logic             ce   [2];
    logic             wr_n [2];
    logic             oe_n [2];
    logic             pipe [2];
    logic [AW-1:0]    addr [2];
    logic [WIDTH-1:0] wd   [2];
    logic [WIDTH-1:0] l_rdata, r_rdata;
    logic             l_rvalid, r_rvalid;

    dual_port_ram #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .l_ce_n(ce_n[0]), .l_ce(ce[0]), .l_wr_n(wr_n[0]), .l_oe_n(oe_n[0]), .l_pipe(pipe[0]),
        .l_addr(addr[0]), .l_wdata(wd[0]), .l_rdata(l_rdata), .l_rvalid(l_rvalid),
        .r_ce_n(ce_n[1]), .r_ce(ce[1]), .r_wr_n(wr_n[1]), .r_oe_n(oe_n[1]), .r_pipe(pipe[1]),
        .r_addr(addr[1]), .r_wdata(wd[1]), .r_rdata(r_rdata), .r_rvalid(r_rvalid)
    );

    // Behavioural reference model
    int ref_mem [DEPTH];
    int m_rd [2], m_rq [2], m_pv [2], m_pd [2];
    int checks = 0;
    int errors = 0;
    int cyc = 0;
    string cur_req = "R9";

    always @(posedge clk) begin
        bit rsel [2];
        if (!rst_n) begin
            for (int p = 0; p < 2; p++) begin
                m_rd[p] = 0; m_rq[p] = 0; m_pv[p] = 0; m_pd[p] = 0;
            end
        end else begin
            for (int p = 0; p < 2; p++) begin
                rsel[p] = !ce_n[p] && ce[p];
                m_pv[p] = m_rd[p];
                m_pd[p] = m_rq[p];
                m_rd[p] = (rsel[p] && wr_n[p]) ? 1 : 0;
                if (rsel[p] && wr_n[p]) m_rq[p] = ref_mem[addr[p]];
            end
            if (rsel[1] && !wr_n[1]) ref_mem[addr[1]] = int'(wd[1]);
            if (rsel[0] && !wr_n[0]) ref_mem[addr[0]] = int'(wd[0]);
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic compare();
        for (int p = 0; p < 2; p++) begin
            int ev, ed, av, ad;
            ev = ((pipe[p] ? m_pv[p] : m_rd[p]) != 0 && !oe_n[p]) ? 1 : 0;
            ed = ev ? (pipe[p] ? m_pd[p] : m_rq[p]) : 0;
            av = (p == 0) ? int'(l_rvalid) : int'(r_rvalid);
            ad = (p == 0) ? int'(l_rdata) : int'(r_rdata);
            checks++;
            if (av != ev || ad != ed) begin
                errors++;
                $display("FAIL %s port %0d: valid %0d data %0h, expected valid %0d data %0h",
                         cur_req, p, av, ad, ev, ed);
            end
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    task automatic drv(input int p, input bit sel, input bit wn, input int a, input int d);
        ce_n[p] = !sel;
        ce[p]   = sel;
        wr_n[p] = wn;
        addr[p] = AW'(a);
        wd[p]   = WIDTH'(d);
    endtask

    initial begin
        for (int p = 0; p < 2; p++) begin
            drv(p, 1'b0, 1'b1, 0, 0);
            oe_n[p] = 1'b0;
            pipe[p] = 1'b0;
        end
        // R9: reset clears output state, even with reads requested
        drv(0, 1'b1, 1'b1, 3, 0);
        repeat (3) step();
        drv(0, 1'b0, 1'b1, 0, 0);
        rst_n = 1'b1;
        step();

        // R2 fill through the left port; R1 right deselected writes (both enable forms) ignored
        cur_req = "R2";
        for (int i = 0; i < DEPTH; i++) begin
            drv(0, 1'b1, 1'b0, i, (i * 37 + 5) & 9'h1FF);
            drv(1, 1'b0, 1'b0, (i + DEPTH - 1) % DEPTH, 9'h155);
            if (i % 2 == 1) begin ce_n[1] = 1'b0; ce[1] = 1'b0; end
            step();
        end
        drv(0, 1'b0, 1'b1, 0, 0);
        drv(1, 1'b0, 1'b1, 0, 0);
        step();

        // R1 and R3: flow-through reads of every word on the right port; left deselected reads
        cur_req = "R3";
        for (int i = 0; i < DEPTH; i++) begin
            drv(1, 1'b1, 1'b1, i, 0);
            drv(0, 1'b0, 1'b1, i, 0);
            if (i % 3 == 0) begin ce_n[0] = 1'b1; ce[0] = 1'b1; end
            step();
        end
        cur_req = "R1";
        drv(1, 1'b0, 1'b1, 0, 0);
        step();
        step();

        // R4: registered-mode reads on both ports
        cur_req = "R4";
        pipe[0] = 1'b1; pipe[1] = 1'b1;
        for (int i = 0; i < 40; i++) begin
            drv(0, 1'b1, 1'b1, i, 0);
            drv(1, 1'b1, 1'b1, 255 - i, 0);
            step();
        end
        // R6: after a deselect, registered output needs one selected read to return
        cur_req = "R6";
        drv(0, 1'b0, 1'b1, 0, 0);
        step();
        drv(0, 1'b1, 1'b1, 9, 0);
        step();
        step();
        step();

        // R5: output enable toggled asynchronously while reading
        cur_req = "R5";
        for (int i = 0; i < 30; i++) begin
            pipe[0] = (i % 4 < 2);
            drv(0, 1'b1, 1'b1, i, 0);
            drv(1, 1'b1, 1'b1, i + 1, 0);
            oe_n[0] = i[0];
            oe_n[1] = ~i[0];
            #1;
            checks++;
            if (oe_n[0] && l_rvalid) begin
                errors++;
                $display("FAIL R5 left: valid %0d, expected 0 right after output enable rose", l_rvalid);
            end
            step();
        end
        oe_n[0] = 1'b0; oe_n[1] = 1'b0;

        // R7: write/read collision on one word, then read back
        cur_req = "R7";
        pipe[0] = 1'b0; pipe[1] = 1'b0;
        drv(0, 1'b1, 1'b0, 5, 9'h0A3);
        drv(1, 1'b1, 1'b1, 5, 0);
        step();
        drv(0, 1'b1, 1'b1, 6, 0);
        step();
        drv(0, 1'b0, 1'b1, 0, 0);
        step();

        // R8: both ports write one word, the left data must remain
        cur_req = "R8";
        drv(0, 1'b1, 1'b0, 7, 9'h111);
        drv(1, 1'b1, 1'b0, 7, 9'h0EE);
        step();
        drv(0, 1'b1, 1'b1, 7, 0);
        drv(1, 1'b1, 1'b1, 7, 0);
        step();
        step();

        // R10 with R6/R7/R8 mixed: random traffic over a small address range, modes switching
        cur_req = "R10";
        for (int i = 0; i < 3000; i++) begin
            for (int p = 0; p < 2; p++) begin
                int r;
                r = int'($urandom);
                ce_n[p] = (r % 7 == 0);
                ce[p]   = (r % 11 != 0);
                wr_n[p] = (r % 3 != 0);
                addr[p] = AW'((r >> 4) % 8);
                wd[p]   = WIDTH'(r >> 12);
                pipe[p] = ((r >> 8) % 5 < 2);
                oe_n[p] = ((r >> 16) % 9 == 0);
            end
            step();
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule